// File: doc/BRIEF.md
# Dual-Sequencer ADC Status Register

This block holds the status and flag word for an ADC that runs two independent conversion sequencers. Each sequencer sends it a one-cycle end-of-sequence pulse, a busy level and an interrupt-mode select. From these the block keeps one interrupt flag and one parity buffer bit per sequencer, and it drives a matching interrupt request line for each flag.

In interrupt mode 0 every end of sequence raises the flag. In mode 1 the parity bit inverts on each end of sequence, so the flag is raised only on every second sequence end: the 2nd, the 4th, and so on, counted from device reset. Software reads the word over a simple synchronous bus. It lowers a flag by writing 1 to that flag's clear bit. A clear bit is a one-cycle action and always reads back as zero.

Top module: `seq_status_reg`

## Requirements
- R1: Read bits 15..8 always return zero, and data written to those bit positions has no effect on any state.
- R2: While rdEn and addrHit are both 1, rdData bits 7..0 read as follows, from bit 7 down: parity 2, parity 1, clear 2, clear 1, busy 2, busy 1, flag 2, flag 1. Otherwise rdData is all zero.
- R3: In mode 0 a parity bit becomes 0 at the next clock and stays there. This includes a switch from mode 1 to mode 0. In mode 1 the parity bit inverts at the clock that samples an end-of-sequence pulse of its sequencer, and otherwise it holds.
- R4: Only device reset clears a parity bit. Clearing the matching flag leaves the parity bit unchanged.
- R5: In mode 0 every end-of-sequence pulse sets the flag at the next clock. In mode 1 a pulse sets the flag only if the parity bit was 1 before that same pulse toggled it. As a result the flag rises on the 2nd, 4th and later even-numbered events.
- R6: A bus write with addrHit=1 and wrData bit 4 (sequencer 1) or bit 5 (sequencer 2) set to 1 clears that flag at the next clock. Writing 0 to those bits, or writing while addrHit=0, changes nothing. Both clear bits always read as 0.
- R7: If a flag set and a clear of the same flag fall in the same cycle, the flag is 1 afterwards.
- R8: Bits 3 and 2 show the busy inputs of sequencers 2 and 1 in the same cycle, with no register delay.
- R9: Writes to the flag, busy and parity bit positions have no effect.
- R10: irq[i] always equals flag i. While rstN is low at a clock edge, all flags and parity bits become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Device reset, active low, synchronous |
| eosPulse | input | 2 | One-cycle end-of-sequence pulse, one bit per sequencer |
| busy | input | 2 | Sequencer in-progress levels |
| intMode | input | 2 | Interrupt mode select per sequencer (1 = every second end) |
| wrEn | input | 1 | Bus write strobe |
| rdEn | input | 1 | Bus read strobe |
| addrHit | input | 1 | Bus address matches this register |
| wrData | input | 16 | Bus write data |
| rdData | output | 16 | Bus read data, combinational |
| irq | output | 2 | Interrupt request per sequencer |

## Verification
A parity bit holding the wrong value stays hidden until the next end-of-sequence pulse in mode 1. It then shows as a flag rising on an odd event, or missing on an even one, one clock after that pulse. It can also be seen at once in bits 7..6 of any read. A flag that is set or cleared wrongly shows on irq and in bits 1..0 in the cycle after the clock that caused it. Long random runs with mode switches, clears that collide with sets, and occasional resets keep both views compared against a cycle model every cycle.

// File: rtl/seq_status_pkg.sv
package seq_status_pkg;
  localparam int NUM_SEQ = 2;

  typedef struct packed {
    logic [NUM_SEQ-1:0] setFlag;
    logic [NUM_SEQ-1:0] clrFlag;
    logic [NUM_SEQ-1:0] togBuf;
    logic [NUM_SEQ-1:0] zeroBuf;
  } strobes_t;
endpackage

// File: rtl/seq_status_ctrl.sv
module seq_status_ctrl
  import seq_status_pkg::*;
(
  input  logic [NUM_SEQ-1:0] eosPulse,
  input  logic [NUM_SEQ-1:0] intMode,
  input  logic [NUM_SEQ-1:0] clrBits,
  input  logic [NUM_SEQ-1:0] bufQ,
  input  logic               wrHit,
  output strobes_t           stb
);
  always_comb begin
    // decision uses the parity value from before this event's toggle
    stb.setFlag = eosPulse & (~intMode | bufQ);
    stb.clrFlag = {NUM_SEQ{wrHit}} & clrBits;
    stb.togBuf  = eosPulse & intMode;
    stb.zeroBuf = ~intMode;
  end
endmodule

// File: rtl/seq_status_dp.sv
module seq_status_dp
  import seq_status_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobes_t           stb,
  input  logic [NUM_SEQ-1:0] busy,
  input  logic               rdSel,
  output logic [NUM_SEQ-1:0] flagQ,
  output logic [NUM_SEQ-1:0] bufQ,
  output logic [DATA_W-1:0]  rdData
);
  localparam int FLAG_LSB = 0;
  localparam int BUSY_LSB = NUM_SEQ;
  localparam int BUF_LSB  = 3 * NUM_SEQ;

  for (genvar g = 0; g < NUM_SEQ; g++) begin : g_seq
    logic flagR;
    logic bufR;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        flagR <= 1'b0;
        bufR  <= 1'b0;
      end else begin
        if (stb.setFlag[g])      flagR <= 1'b1;
        else if (stb.clrFlag[g]) flagR <= 1'b0;

        if (stb.zeroBuf[g])      bufR <= 1'b0;
        else if (stb.togBuf[g])  bufR <= ~bufR;
      end
    end

    assign flagQ[g] = flagR;
    assign bufQ[g]  = bufR;
  end

  always_comb begin
    rdData = '0;
    if (rdSel) begin
      rdData[FLAG_LSB +: NUM_SEQ] = flagQ;
      rdData[BUSY_LSB +: NUM_SEQ] = busy;
      rdData[BUF_LSB  +: NUM_SEQ] = bufQ;
    end
  end
endmodule

// File: rtl/seq_status_reg.sv
module seq_status_reg
  import seq_status_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SEQ-1:0] eosPulse,
  input  logic [NUM_SEQ-1:0] busy,
  input  logic [NUM_SEQ-1:0] intMode,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic               addrHit,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  output logic [NUM_SEQ-1:0] irq
);
  localparam int CLR_LSB = 2 * NUM_SEQ;
  localparam int BUF_LSB = 3 * NUM_SEQ;

  strobes_t           stb;
  logic [NUM_SEQ-1:0] flagQ;
  logic [NUM_SEQ-1:0] bufQ;
  logic               unusedWr;

  assign unusedWr = ^{wrData[DATA_W-1:BUF_LSB], wrData[CLR_LSB-1:0]};

  seq_status_ctrl ctrl_i (
    .eosPulse (eosPulse),
    .intMode  (intMode),
    .clrBits  (wrData[CLR_LSB +: NUM_SEQ]),
    .bufQ     (bufQ),
    .wrHit    (wrEn & addrHit),
    .stb      (stb)
  );

  seq_status_dp #(.DATA_W(DATA_W)) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .busy   (busy),
    .rdSel  (rdEn & addrHit),
    .flagQ  (flagQ),
    .bufQ   (bufQ),
    .rdData (rdData)
  );

  assign irq = flagQ;
endmodule

// File: rtl/seq_status_chk.sv
module seq_status_chk
  import seq_status_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SEQ-1:0] eosPulse,
  input logic [NUM_SEQ-1:0] intMode,
  input logic               wrEn,
  input logic               rdEn,
  input logic               addrHit,
  input logic [DATA_W-1:0]  wrData,
  input logic [DATA_W-1:0]  rdData,
  input logic [NUM_SEQ-1:0] irq,
  input logic [NUM_SEQ-1:0] bufQ
);
  localparam int CLR_LSB = 2 * NUM_SEQ;
  localparam int USED_W  = 4 * NUM_SEQ;

  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    rdData[DATA_W-1:USED_W] == '0);

  a_r2_idle_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    !(rdEn && addrHit) |-> rdData == '0);

  a_r6_clr_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    rdData[CLR_LSB +: NUM_SEQ] == '0);

  a_r10_reset_clears: assert property (@(posedge clk)
    !rstN |=> (irq == '0 && bufQ == '0));

  for (genvar g = 0; g < NUM_SEQ; g++) begin : g_chk
    a_r3_mode0_buf_zero: assert property (@(posedge clk) disable iff (!rstN)
      !intMode[g] |=> bufQ[g] == 1'b0);

    a_r3_mode1_toggle: assert property (@(posedge clk) disable iff (!rstN)
      (intMode[g] && eosPulse[g]) |=> bufQ[g] != $past(bufQ[g]));

    a_r4_buf_hold: assert property (@(posedge clk) disable iff (!rstN)
      (intMode[g] && !eosPulse[g]) |=> $stable(bufQ[g]));

    a_r5_odd_event_no_set: assert property (@(posedge clk) disable iff (!rstN)
      (eosPulse[g] && intMode[g] && !bufQ[g] && !irq[g]) |=> !irq[g]);

    a_r7_set_beats_clear: assert property (@(posedge clk) disable iff (!rstN)
      (eosPulse[g] && (!intMode[g] || bufQ[g])) |=> irq[g]);

    a_r6_clear_lowers: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && addrHit && wrData[CLR_LSB + g] && !eosPulse[g]) |=> !irq[g]);
  end
endmodule

bind seq_status_reg seq_status_chk #(.DATA_W(DATA_W)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .eosPulse (eosPulse),
  .intMode  (intMode),
  .wrEn     (wrEn),
  .rdEn     (rdEn),
  .addrHit  (addrHit),
  .wrData   (wrData),
  .rdData   (rdData),
  .irq      (irq),
  .bufQ     (bufQ)
);

// File: tb/seq_status_reg_tb.sv
module seq_status_reg_tb_top;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  eosPulse = '0;
  logic [1:0]  busy = '0;
  logic [1:0]  intMode = '0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic        addrHit = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic [1:0]  irq;

  int checks = 0;
  int fails = 0;

  logic [1:0] mFlag = '0;
  logic [1:0] mBuf = '0;
  logic [1:0] curMode = '0;
  logic [1:0] curBusy = '0;

  seq_status_reg dut_i (
    .clk(clk), .rstN(rstN), .eosPulse(eosPulse), .busy(busy), .intMode(intMode),
    .wrEn(wrEn), .rdEn(rdEn), .addrHit(addrHit), .wrData(wrData),
    .rdData(rdData), .irq(irq)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [15:0] expRd(input logic sel, input logic [1:0] bsy);
    return sel ? {8'h00, mBuf, 2'b00, bsy, mFlag} : 16'h0000;
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // one bus/event cycle: drive at negedge, compare, then advance the model at posedge
  task automatic cyc(input string tag, input logic [1:0] eos, input logic wr,
                     input logic hit, input logic rd, input logic [15:0] d,
                     input logic rst, input logic useLit, input logic [15:0] lit);
    logic [1:0] setV;
    logic [1:0] clrV;
    @(negedge clk);
    rstN = rst; eosPulse = eos; intMode = curMode; busy = curBusy;
    wrEn = wr; addrHit = hit; rdEn = rd; wrData = d;
    #1;
    check(tag, rdData, expRd(rd && hit, curBusy));
    check("R10", {14'b0, irq}, {14'b0, mFlag});
    if (useLit) check(tag, rdData, lit);
    @(posedge clk);
    if (!rst) begin
      mFlag = '0; mBuf = '0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        setV[i] = eos[i] && (!curMode[i] || mBuf[i]);
        clrV[i] = wr && hit && d[4 + i];
        if (setV[i]) mFlag[i] = 1'b1;
        else if (clrV[i]) mFlag[i] = 1'b0;
        if (!curMode[i]) mBuf[i] = 1'b0;
        else if (eos[i]) mBuf[i] = ~mBuf[i];
      end
    end
  endtask

  task automatic peek(input string tag, input logic [15:0] lit);
    cyc(tag, 2'b00, 1'b0, 1'b1, 1'b1, 16'h0, 1'b1, 1'b1, lit);
  endtask

  task automatic ev(input string tag, input logic [1:0] eos, input logic wr, input logic [15:0] d);
    cyc(tag, eos, wr, 1'b1, 1'b1, d, 1'b1, 1'b0, 16'h0);
  endtask

  initial begin
    #(PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int k = 0; k < 3; k++)
      cyc("R10", 2'b00, 1'b0, 1'b1, 1'b1, 16'h0, 1'b0, 1'b0, 16'h0);
    peek("R10", 16'h0000);
    // R8 busy passthrough
    curBusy = 2'b10; peek("R8", 16'h0008);
    curBusy = 2'b01; peek("R8", 16'h0004);
    curBusy = 2'b00;
    // R5 mode 0: every event sets
    ev("R5", 2'b01, 1'b0, 16'h0); peek("R5", 16'h0001);
    // R6: zero write, unmatched address, then real clear
    ev("R6", 2'b00, 1'b1, 16'h0000); peek("R6", 16'h0001);
    cyc("R6", 2'b00, 1'b1, 1'b0, 1'b1, 16'h0010, 1'b1, 1'b0, 16'h0);
    peek("R6", 16'h0001);
    ev("R6", 2'b00, 1'b1, 16'h0010); peek("R6", 16'h0000);
    // R1 / R9: writes to reserved, flag, busy, parity positions
    ev("R9", 2'b00, 1'b1, 16'hFFCF); peek("R1", 16'h0000);
    // R7: set and clear together
    ev("R7", 2'b01, 1'b1, 16'h0010); peek("R7", 16'h0001);
    ev("R6", 2'b00, 1'b1, 16'h0010); peek("R6", 16'h0000);
    // mode 1 on sequencer 2: flag on even events only
    curMode = 2'b10;
    ev("R3", 2'b10, 1'b0, 16'h0); peek("R5", 16'h0080);
    ev("R5", 2'b10, 1'b0, 16'h0); peek("R5", 16'h0002);
    ev("R3", 2'b10, 1'b0, 16'h0); peek("R3", 16'h0082);
    ev("R4", 2'b00, 1'b1, 16'h0020); peek("R4", 16'h0080);
    ev("R5", 2'b10, 1'b0, 16'h0); peek("R5", 16'h0002);
    ev("R3", 2'b10, 1'b0, 16'h0); peek("R3", 16'h0082);
    // R3: leaving mode 1 zeroes parity at the next clock
    curMode = 2'b00;
    peek("R3", 16'h0082);
    peek("R3", 16'h0002);
    ev("R6", 2'b00, 1'b1, 16'h0020); peek("R6", 16'h0000);
    // random phase, R2 layout checked every cycle against the model
    for (int n = 0; n < 4000; n++) begin
      if ($urandom % 16 == 0) curMode = 2'($urandom);
      curBusy = 2'($urandom);
      cyc("R2", 2'($urandom), ($urandom % 4 == 0), ($urandom % 4 != 0),
          ($urandom % 4 != 0), 16'($urandom), ($urandom % 200 != 0), 1'b0, 16'h0);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule